// File: doc/BRIEF.md
# Multi-Buffer Instruction Parcel Fetch

This block feeds 16-bit instruction parcels to an issue stage. All parcels come from a small set of instruction buffers. Each buffer holds one aligned block of parcels and a tag for that block. Every time the program counter moves, the block looks the addressed parcel up in all buffers at once. When no buffer holds it, a state machine asks memory for the whole aligned block over a valid/ready request. It then takes the block's parcels one beat at a time into a buffer chosen round-robin. Fetching resumes once the last beat has been written.

Fetched parcels pass through a two-stage path. A next-parcel register is loaded from the buffers. It is copied into a current-parcel register, where the parcel waits for issue. Bit 15 of a parcel is its length bit. When that bit is set, the instruction also has a second parcel. That parcel is read at the same time and loaded into a lower-parcel register alongside the next-parcel register, then travels with it. An issue-stall input freezes the path and the program counter. A redirect input loads a new program counter and discards the parcels in flight.

The controller has three states:
- `FS_RUN` does lookups and advances the path.
- `FS_REQ` holds the memory request until it is accepted.
- `FS_FILL` writes the response beats into the chosen buffer.

Its transitions are:
- RUN→REQ on a miss (this also invalidates the chosen buffer).
- REQ→FILL when the request is accepted.
- FILL→RUN on the last beat of the block.

Top module: `parcel_fetch`

## Requirements
- R1: While reset is asserted and right after it is released, `cip_valid`, `issue_fire` and `mem_req_valid` are all 0, and fetching starts at address 0.
- R2: Issued parcels follow program order. After a parcel at address a, the next issued parcel comes from a+1 when its bit 15 is 0, and from a+2 when bit 15 is 1. Addresses wrap modulo 4096.
- R3: When an issued parcel has bit 15 set, `cip_lower` carries the parcel at the following address, even when that address lies in another block. When bit 15 is clear, `cip_lower` is 0.
- R4: A miss on either the first or the second parcel of an instruction raises one request. Its `mem_req_addr` is the missing block's first parcel address, with the low 6 bits zero.
- R5: A fill takes exactly 64 response beats. No new request is raised before the last beat has been taken.
- R6: A parcel whose block is held in any of the four buffers is served without a memory request.
- R7: A refill goes to the buffers in round-robin order, so a fifth distinct block evicts the block that was filled earliest.
- R8: While `stall` is 1 (and there is no redirect), `issue_fire` is 0, the current parcel and its valid bit hold, and the program counter does not advance.
- R9: While a request or a fill is pending, `issue_fire` is 0 and the current parcel holds.
- R10: A redirect flushes the next and current parcels, issues nothing in its cycle, and makes the redirect address the next parcel issued.
- R11: A raised request keeps `mem_req_valid` high and `mem_req_addr` unchanged until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Issue stall: freezes the parcel path and the program counter |
| redirect | input | 1 | Load `redirect_pc` into the program counter and flush parcels in flight |
| redirect_pc | input | 12 | Parcel address to continue from |
| mem_req_valid | output | 1 | Block fill request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 12 | Parcel address of the requested block's first parcel |
| mem_rsp_valid | input | 1 | One response beat present |
| mem_rsp_data | input | 16 | Response parcel, in ascending address order |
| issue_fire | output | 1 | The current parcel is issued at this clock edge |
| cip_valid | output | 1 | The current-parcel register holds a parcel |
| cip_parcel | output | 16 | Current parcel (bit 15 = length bit) |
| cip_lower | output | 16 | Second parcel of a two-parcel instruction, else 0 |

## Verification
The checker assumes that memory is well behaved. Response beats arrive only after a request has been accepted, there are exactly 64 of them, they come in ascending address order, and none arrive outside a fill. The block has no response-ready signal, so a beat arriving at any other time would be written nowhere or into the wrong slot.

The bench's memory model starts streaming only after it has seen an accepted request. It counts the beats down from 64 and leaves gaps between them. It also delays `mem_req_ready` on some cycles so that the request has to be held. Redirects are applied freely, including while a fill is in progress, because the block is meant to handle them in any state.

// File: rtl/parcel_fetch_pkg.sv
package parcel_fetch_pkg;

    typedef enum logic [1:0] {
        FS_RUN  = 2'd0,
        FS_REQ  = 2'd1,
        FS_FILL = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/parcel_fetch_bufs.sv
module parcel_fetch_bufs #(
    parameter int PW   = 16,
    parameter int PCW  = 12,
    parameter int NBUF = 4,
    parameter int BLK  = 64,
    localparam int OFFW = $clog2(BLK),
    localparam int TAGW = PCW - OFFW,
    localparam int BUFW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PCW-1:0]  rd_pc_a,
    input  logic [PCW-1:0]  rd_pc_b,
    output logic            hit_a,
    output logic            hit_b,
    output logic [PW-1:0]   data_a,
    output logic [PW-1:0]   data_b,
    input  logic            wr_en,
    input  logic [BUFW-1:0] wr_buf,
    input  logic [OFFW-1:0] wr_off,
    input  logic [PW-1:0]   wr_data,
    input  logic            inv_en,
    input  logic            set_en,
    input  logic [TAGW-1:0] set_tag
);

    logic [PW-1:0]   store   [NBUF][BLK];
    logic [TAGW-1:0] tag_q   [NBUF];
    logic [NBUF-1:0] tag_vld;
    logic [NBUF-1:0] match_a;
    logic [NBUF-1:0] match_b;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_buf][wr_off] <= wr_data;
        end
    end

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_vld[b] <= 1'b0;
                tag_q[b]   <= '0;
            end else if (wr_buf == BUFW'(b)) begin
                if (inv_en) begin
                    tag_vld[b] <= 1'b0;
                end else if (set_en) begin
                    tag_vld[b] <= 1'b1;
                    tag_q[b]   <= set_tag;
                end
            end
        end
        assign match_a[b] = tag_vld[b] && (tag_q[b] == rd_pc_a[PCW-1:OFFW]);
        assign match_b[b] = tag_vld[b] && (tag_q[b] == rd_pc_b[PCW-1:OFFW]);
    end

    always_comb begin
        data_a = '0;
        data_b = '0;
        for (int b = 0; b < NBUF; b++) begin
            if (match_a[b]) data_a = data_a | store[b][rd_pc_a[OFFW-1:0]];
            if (match_b[b]) data_b = data_b | store[b][rd_pc_b[OFFW-1:0]];
        end
    end

    assign hit_a = |match_a;
    assign hit_b = |match_b;

endmodule

// File: rtl/parcel_fetch_fill.sv
module parcel_fetch_fill
    import parcel_fetch_pkg::*;
#(
    parameter int NBUF = 4,
    parameter int BLK  = 64,
    parameter int TAGW = 6,
    localparam int OFFW = $clog2(BLK),
    localparam int BUFW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            miss,
    input  logic [TAGW-1:0] miss_tag,
    input  logic            mem_req_ready,
    input  logic            mem_rsp_valid,
    output logic            running,
    output logic            filling,
    output logic            req_valid,
    output logic [TAGW-1:0] req_tag,
    output logic            wr_en,
    output logic [BUFW-1:0] wr_buf,
    output logic [OFFW-1:0] wr_off,
    output logic            inv_en,
    output logic            set_en
);

    fetch_state_e    state_q, state_d;
    logic [TAGW-1:0] blk_q;
    logic [OFFW-1:0] beat_q;
    logic [BUFW-1:0] victim_q;
    logic            last_beat;

    assign last_beat = (beat_q == OFFW'(BLK - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_RUN;
        else        state_q <= state_d;
    end

    // transitions: RUN->REQ on miss, REQ->FILL on accept, FILL->RUN on last beat
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_RUN:  if (miss)                       state_d = FS_REQ;
            FS_REQ:  if (mem_req_ready)              state_d = FS_FILL;
            FS_FILL: if (mem_rsp_valid && last_beat) state_d = FS_RUN;
            default:                                 state_d = FS_RUN;
        endcase
    end

    // outputs
    always_comb begin
        running   = 1'b0;
        filling   = 1'b0;
        req_valid = 1'b0;
        wr_en     = 1'b0;
        inv_en    = 1'b0;
        set_en    = 1'b0;
        unique case (state_q)
            FS_RUN: begin
                running = 1'b1;
                inv_en  = miss;
            end
            FS_REQ: begin
                req_valid = 1'b1;
            end
            FS_FILL: begin
                filling = 1'b1;
                wr_en   = mem_rsp_valid;
                set_en  = mem_rsp_valid && last_beat;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q    <= '0;
            beat_q   <= '0;
            victim_q <= '0;
        end else begin
            if (running && miss) begin
                blk_q <= miss_tag;
            end
            if (req_valid && mem_req_ready) begin
                beat_q <= '0;
            end else if (wr_en) begin
                beat_q <= beat_q + 1'b1;
            end
            if (set_en) begin
                victim_q <= (victim_q == BUFW'(NBUF - 1)) ? '0 : victim_q + 1'b1;
            end
        end
    end

    assign req_tag = blk_q;
    assign wr_buf  = victim_q;
    assign wr_off  = beat_q;

endmodule

// File: rtl/parcel_fetch.sv
module parcel_fetch
    import parcel_fetch_pkg::*;
#(
    parameter int PW       = 16,
    parameter int PCW      = 12,
    parameter int NBUF     = 4,
    parameter int BLK      = 64,
    parameter int RESET_PC = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stall,
    input  logic           redirect,
    input  logic [PCW-1:0] redirect_pc,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic [PCW-1:0] mem_req_addr,
    input  logic           mem_rsp_valid,
    input  logic [PW-1:0]  mem_rsp_data,
    output logic           issue_fire,
    output logic           cip_valid,
    output logic [PW-1:0]  cip_parcel,
    output logic [PW-1:0]  cip_lower
);

    localparam int OFFW    = $clog2(BLK);
    localparam int TAGW    = PCW - OFFW;
    localparam int BUFW    = (NBUF > 1) ? $clog2(NBUF) : 1;
    localparam int LEN_BIT = PW - 1;

    logic [PCW-1:0]  pc_q, pc_nx1;
    logic            nip_valid;
    logic [PW-1:0]   nip_q, lip_q;
    logic            hit0, hit1;
    logic [PW-1:0]   rd0, rd1;
    logic            two0, fetch_ok, miss, advance;
    logic [TAGW-1:0] miss_tag, req_tag;
    logic            running, filling;
    logic            wr_en, inv_en, set_en;
    logic [BUFW-1:0] wr_buf;
    logic [OFFW-1:0] wr_off;

    assign pc_nx1   = pc_q + 1'b1;
    assign two0     = rd0[LEN_BIT];
    assign fetch_ok = running && hit0 && (!two0 || hit1);
    assign miss     = running && !redirect && !fetch_ok;
    assign miss_tag = hit0 ? pc_nx1[PCW-1:OFFW] : pc_q[PCW-1:OFFW];
    assign advance  = !redirect && !stall && fetch_ok;

    parcel_fetch_bufs #(.PW(PW), .PCW(PCW), .NBUF(NBUF), .BLK(BLK)) u_bufs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_pc_a (pc_q),
        .rd_pc_b (pc_nx1),
        .hit_a   (hit0),
        .hit_b   (hit1),
        .data_a  (rd0),
        .data_b  (rd1),
        .wr_en   (wr_en),
        .wr_buf  (wr_buf),
        .wr_off  (wr_off),
        .wr_data (mem_rsp_data),
        .inv_en  (inv_en),
        .set_en  (set_en),
        .set_tag (req_tag)
    );

    parcel_fetch_fill #(.NBUF(NBUF), .BLK(BLK), .TAGW(TAGW)) u_fill (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss          (miss),
        .miss_tag      (miss_tag),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .running       (running),
        .filling       (filling),
        .req_valid     (mem_req_valid),
        .req_tag       (req_tag),
        .wr_en         (wr_en),
        .wr_buf        (wr_buf),
        .wr_off        (wr_off),
        .inv_en        (inv_en),
        .set_en        (set_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q       <= PCW'(RESET_PC);
            nip_valid  <= 1'b0;
            nip_q      <= '0;
            lip_q      <= '0;
            cip_valid  <= 1'b0;
            cip_parcel <= '0;
            cip_lower  <= '0;
        end else if (redirect) begin
            pc_q      <= redirect_pc;
            nip_valid <= 1'b0;
            cip_valid <= 1'b0;
        end else if (advance) begin
            cip_valid  <= nip_valid;
            cip_parcel <= nip_q;
            cip_lower  <= lip_q;
            nip_valid  <= 1'b1;
            nip_q      <= rd0;
            lip_q      <= two0 ? rd1 : '0;
            pc_q       <= pc_q + (two0 ? PCW'(2) : PCW'(1));
        end
    end

    assign issue_fire   = advance && cip_valid;
    assign mem_req_addr = {req_tag, {OFFW{1'b0}}};

endmodule

// File: rtl/parcel_fetch_chk.sv
module parcel_fetch_chk #(
    parameter int PW  = 16,
    parameter int PCW = 12,
    parameter int BLK = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           stall,
    input logic           redirect,
    input logic           issue_fire,
    input logic           cip_valid,
    input logic [PW-1:0]  cip_parcel,
    input logic [PW-1:0]  cip_lower,
    input logic           mem_req_valid,
    input logic           mem_req_ready,
    input logic [PCW-1:0] mem_req_addr,
    input logic           mem_rsp_valid,
    input logic           filling
);

    localparam int CW = $clog2(BLK + 1) + 1;

    logic [CW-1:0] beats;
    logic          was_fill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats    <= '0;
            was_fill <= 1'b0;
        end else begin
            was_fill <= filling;
            if (mem_req_valid && mem_req_ready) beats <= '0;
            else if (filling && mem_rsp_valid)  beats <= beats + 1'b1;
        end
    end

    a_r8_stall_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !issue_fire);

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !redirect) |=> ($stable(cip_parcel) && $stable(cip_valid)));

    a_r9_fill_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (filling || mem_req_valid) |-> !issue_fire);

    a_r9_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (filling && !redirect) |=> $stable(cip_parcel));

    a_r10_redirect_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> !issue_fire);

    a_r10_redirect_flush: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !cip_valid);

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r5_fill_beats: assert property (@(posedge clk) disable iff (!rst_n)
        (was_fill && !filling) |-> (beats == CW'(BLK)));

    a_r3_single_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (cip_valid && !cip_parcel[PW-1]) |-> (cip_lower == '0));

endmodule

bind parcel_fetch parcel_fetch_chk #(.PW(PW), .PCW(PCW), .BLK(BLK)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall         (stall),
    .redirect      (redirect),
    .issue_fire    (issue_fire),
    .cip_valid     (cip_valid),
    .cip_parcel    (cip_parcel),
    .cip_lower     (cip_lower),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .filling       (filling)
);

// File: tb/parcel_fetch_bench.sv
module parcel_fetch_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PW   = 16;
    localparam int PCW  = 12;
    localparam int NBUF = 4;
    localparam int BLK  = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           stall = 1'b0;
    logic           redirect = 1'b0;
    logic [PCW-1:0] redirect_pc = '0;
    logic           mem_req_valid;
    logic           mem_req_ready = 1'b0;
    logic [PCW-1:0] mem_req_addr;
    logic           mem_rsp_valid = 1'b0;
    logic [PW-1:0]  mem_rsp_data = '0;
    logic           issue_fire;
    logic           cip_valid;
    logic [PW-1:0]  cip_parcel;
    logic [PW-1:0]  cip_lower;

    parcel_fetch #(.PW(PW), .PCW(PCW), .NBUF(NBUF), .BLK(BLK)) u_parcel_fetch (
        .clk(clk), .rst_n(rst_n), .stall(stall), .redirect(redirect),
        .redirect_pc(redirect_pc), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .issue_fire(issue_fire), .cip_valid(cip_valid),
        .cip_parcel(cip_parcel), .cip_lower(cip_lower)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int cyc = 0, issued = 0, req_count = 0;
    int beats_left = 0, fill_idx = 0;
    logic [PCW-1:0] fill_base = '0;
    logic [PCW-1:0] exp_pc = '0;
    int model_blk [NBUF];
    int model_vic = 0;
    logic           hold_pending = 1'b0, hold_valid = 1'b0;
    logic [PW-1:0]  hold_parcel = '0;
    logic           req_wait = 1'b0;
    logic [PCW-1:0] req_wait_addr = '0;
    bit             done = 1'b0;

    // parcel contents: bit 15 set when address mod 5 is 2
    function automatic logic [PW-1:0] mem_word(input logic [PCW-1:0] a);
        logic lenb;
        lenb = ((int'(a) % 5) == 2);
        return {lenb, 15'(int'(a) * 37 + 11)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic st, input logic rd, input logic [PCW-1:0] tg);
        logic rsp_now;
        bit   resident;
        @(negedge clk);
        cyc++;
        stall         = st;
        redirect      = rd;
        redirect_pc   = tg;
        mem_req_ready = (cyc % 3 != 1);
        rsp_now       = (beats_left > 0) && (cyc % 5 != 4);
        mem_rsp_valid = rsp_now;
        mem_rsp_data  = rsp_now ? mem_word(fill_base + PCW'(fill_idx)) : '0;
        #1;
        if (hold_pending)
            chk(cip_parcel == hold_parcel && cip_valid == hold_valid, "R8 hold",
                {15'd0, cip_valid, cip_parcel}, {15'd0, hold_valid, hold_parcel});
        hold_pending = st && !rd;
        hold_parcel  = cip_parcel;
        hold_valid   = cip_valid;
        if (req_wait)
            chk(mem_req_valid && mem_req_addr == req_wait_addr, "R11 request held",
                {19'd0, mem_req_valid, mem_req_addr}, {19'd0, 1'b1, req_wait_addr});
        req_wait      = mem_req_valid && !mem_req_ready;
        req_wait_addr = mem_req_addr;
        if (st) chk(!issue_fire, "R8 no issue", 32'(issue_fire), 0);
        if (rd) chk(!issue_fire, "R10 no issue", 32'(issue_fire), 0);
        if (beats_left > 0) begin
            chk(!issue_fire, "R9 no issue in fill", 32'(issue_fire), 0);
            chk(!mem_req_valid, "R5 no request in fill", 32'(mem_req_valid), 0);
        end
        if (issue_fire) begin
            chk(cip_parcel == mem_word(exp_pc), "R2 parcel", 32'(cip_parcel), 32'(mem_word(exp_pc)));
            if (mem_word(exp_pc)[PW-1]) begin
                chk(cip_lower == mem_word(exp_pc + 1'b1), "R3 lower parcel",
                    32'(cip_lower), 32'(mem_word(exp_pc + 1'b1)));
                exp_pc = exp_pc + 2'd2;
            end else begin
                chk(cip_lower == '0, "R3 single lower zero", 32'(cip_lower), 0);
                exp_pc = exp_pc + 1'b1;
            end
            issued++;
        end
        if (rd) exp_pc = tg;
        if (rsp_now) begin
            fill_idx++;
            beats_left--;
        end
        if (mem_req_valid && mem_req_ready) begin
            req_count++;
            chk(mem_req_addr[5:0] == 6'd0, "R4 aligned", 32'(mem_req_addr), 32'(mem_req_addr & 12'hfc0));
            resident = 1'b0;
            for (int b = 0; b < NBUF; b++)
                if (model_blk[b] == int'(mem_req_addr[PCW-1:6])) resident = 1'b1;
            chk(!resident, "R6/R7 request only for non-resident block",
                32'(mem_req_addr[PCW-1:6]), 32'hffffffff);
            model_blk[model_vic] = int'(mem_req_addr[PCW-1:6]);
            model_vic  = (model_vic + 1) % NBUF;
            fill_base  = mem_req_addr;
            fill_idx   = 0;
            beats_left = BLK;
        end
    endtask

    function automatic logic stall_fn(input int mode);
        case (mode)
            1:       return (cyc % 7 == 2) || (cyc % 7 == 3);
            2:       return (cyc % 3 == 0);
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_issues(input int n, input int mode);
        int target, lim;
        target = issued + n;
        lim    = cyc + 20 * n + 2000;
        while (issued < target && cyc < lim) tick(stall_fn(mode), 1'b0, '0);
        if (issued < target) chk(1'b0, "R2 progress", 32'(issued), 32'(target));
    endtask

    task automatic jump(input logic [PCW-1:0] tg);
        tick(1'b0, 1'b1, tg);
    endtask

    initial begin
        int rc;
        for (int b = 0; b < NBUF; b++) model_blk[b] = -1;
        repeat (3) @(negedge clk);
        chk(!cip_valid && !issue_fire && !mem_req_valid, "R1 in reset",
            {29'd0, cip_valid, issue_fire, mem_req_valid}, 0);
        rst_n = 1'b1;
        #1;
        chk(!cip_valid && !issue_fire && !mem_req_valid, "R1 after reset",
            {29'd0, cip_valid, issue_fire, mem_req_valid}, 0);
        exp_pc = '0;

        // R2/R3/R4/R7: straight-line run from 0 through seven blocks
        run_issues(330, 1);

        // R6: block 4 is still resident
        rc = req_count;
        jump(12'd261);
        run_issues(10, 0);
        chk(req_count == rc, "R6 hit without request", 32'(req_count), 32'(rc));

        // R7: block 1 was evicted in round-robin order
        rc = req_count;
        jump(12'd64);
        run_issues(10, 2);
        chk(req_count == rc + 1, "R7 evicted block refetched", 32'(req_count), 32'(rc + 1));

        // R4: second parcel of a two-parcel instruction lies in a missing block
        rc = req_count;
        jump(12'd127);
        run_issues(3, 0);
        chk(req_count == rc + 1, "R4 straddling miss", 32'(req_count), 32'(rc + 1));

        // R10: redirect while a fill is pending
        jump(12'd2000);
        repeat (6) tick(1'b0, 1'b0, '0);
        jump(12'd3001);
        run_issues(8, 1);

        // sweep of redirect targets and stall patterns
        for (int k = 0; k < 20; k++) begin
            jump(PCW'((k * 211 + 62) % 4096));
            run_issues(6, k % 3);
        end

        // R2: wrap from the top of the address space
        jump(12'd4094);
        run_issues(5, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule